// File: doc/BRIEF.md
# Masked Prefix Popcount Generator

This block turns one source word into a stream of running bit counts. After a start strobe, it emits one element per clock for element indices 0 to VL-1. Element i carries the number of set bits that lie strictly below bit position i in the source word, after the source has been ANDed with a predicate mask. A source flagged as all ones with an all-ones mask therefore yields the plain index sequence 0, 1, 2, … VL-1.

A second mode replaces the source bits with per-element condition tests. Element i reads a 4-bit condition field at position (base + i) modulo 64 from a bank of 64 fields. A 3-bit selector picks one bit of that field and names the polarity that bit must match. Each element then reports how many earlier elements passed their test, subject to the same mask.

The results are meant to feed a vector writeback path. Register-file access and instruction decode sit outside the block.

Top module: `prefix_count_top`

## Requirements
- R1: Element i's count equals the number of positions j < i for which the element hit bit is set, so element 0 always reports 0. In bit mode the hit bit for position j is src_i[j] AND mask bit j.
- R2: A position whose mask_i bit is 0 never adds to any count, in both modes.
- R3: When mask_all_i is 1 at start, the mask is taken as all ones and mask_i has no effect on the results.
- R4: When src_all_i is 1 at start in bit mode, src_i has no effect and the source is taken as all ones. With an all-ones mask, element i then reports i for every i up to VL-1.
- R5: In condition mode, element i uses field f = (cond_base_i + i) mod 64, which occupies cond_bank_i[4f+3:4f]. Its test passes when bit cond_sel_i[1:0] of that field equals cond_sel_i[2]. The hit bit is the test result ANDed with the mask bit, and the source inputs have no effect.
- R6: A start in condition mode with cond_base_i equal to 0 is ignored: no element and no done pulse follow.
- R7: A start with vl_i equal to 0 or greater than 64 is ignored. Otherwise, elements follow on consecutive cycles, with elem_valid_o high from the cycle after start and elem_idx_o counting 0 to VL-1.
- R8: done_o is high for exactly one cycle, in the cycle right after element VL-1, and elem_valid_o is low in that cycle.
- R9: A start strobe that arrives while a stream is in progress is ignored, and the running stream completes unchanged.
- R10: After reset, elem_valid_o and done_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, one cycle |
| vl_i | input | 7 | Element count, 1 to 64 |
| src_i | input | 64 | Source word |
| src_all_i | input | 1 | Treat the source as all ones |
| mask_i | input | 64 | Predicate mask word |
| mask_all_i | input | 1 | Treat the mask as all ones |
| cond_mode_i | input | 1 | 1 selects condition mode |
| cond_bank_i | input | 256 | 64 condition fields of 4 bits each |
| cond_base_i | input | 6 | Field index of element 0 |
| cond_sel_i | input | 3 | Bits [1:0] pick the field bit, bit 2 gives the polarity |
| elem_valid_o | output | 1 | Element output valid |
| elem_idx_o | output | 6 | Element index |
| elem_cnt_o | output | 7 | Exclusive masked count |
| done_o | output | 1 | One-cycle pulse after the last element |

## Verification
All inputs are captured at the clock edge that samples start. Element k is visible during the cycle that begins k+1 edges later, and done follows one cycle after element VL-1. The bench drives stimulus on the falling edge. It raises start for one cycle, then reads element 0 at the next falling edge and one element at each falling edge after that. The done check falls on the falling edge after the last element and the single-pulse check on the edge after that. For ignored starts, the bench watches several falling edges for any valid or done.

// File: rtl/pc_pkg.sv
package pc_pkg;
    typedef enum logic {
        MODE_BITS = 1'b0,
        MODE_COND = 1'b1
    } mode_e;
endpackage

// File: rtl/pc_cond_test.sv
module pc_cond_test (
    input  logic [3:0] field_i,
    input  logic [2:0] sel_i,
    output logic       pass_o
);
    // the selected field bit must match the polarity bit
    always_comb begin
        pass_o = (field_i[sel_i[1:0]] == sel_i[2]);
    end
endmodule

// File: rtl/pc_hit_vec.sv
module pc_hit_vec
    import pc_pkg::*;
#(
    parameter int N    = 64,
    parameter int CF_N = 64,
    localparam int CFW = $clog2(CF_N)
) (
    input  mode_e                 mode_i,
    input  logic [N-1:0]          src_i,
    input  logic                  src_all_i,
    input  logic [N-1:0]          mask_i,
    input  logic                  mask_all_i,
    input  logic [4*CF_N-1:0]     bank_i,
    input  logic [CFW-1:0]        base_i,
    input  logic [2:0]            sel_i,
    output logic [N-1:0]          hits_o
);
    for (genvar g = 0; g < N; g++) begin : g_elem
        logic [CFW-1:0] fidx;
        logic [3:0]     field;
        logic           pass;
        logic           sbit;

        always_comb begin
            fidx  = base_i + CFW'(g);
            field = bank_i[{fidx, 2'b00} +: 4];
        end

        pc_cond_test u_test (
            .field_i (field),
            .sel_i   (sel_i),
            .pass_o  (pass)
        );

        always_comb begin
            sbit      = (mode_i == MODE_COND) ? pass : (src_all_i | src_i[g]);
            hits_o[g] = sbit & (mask_all_i | mask_i[g]);
        end
    end
endmodule

// File: rtl/pc_seq.sv
module pc_seq #(
    parameter int N   = 64,
    localparam int IW  = $clog2(N),
    localparam int VLW = $clog2(N + 1),
    localparam int CW  = $clog2(N + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [VLW-1:0] vl_i,
    input  logic [N-1:0]   hits_i,
    output logic           valid_o,
    output logic [IW-1:0]  idx_o,
    output logic [CW-1:0]  cnt_o,
    output logic           done_o
);
    typedef struct packed {
        logic          busy;
        logic          done;
        logic [IW-1:0] idx;
        logic [IW-1:0] last;
        logic [CW-1:0] acc;
        logic [N-1:0]  hits;
    } seq_t;

    seq_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.idx  = '0;
                st_d.acc  = '0;
                st_d.last = IW'(vl_i - VLW'(1));
                st_d.hits = hits_i;
            end
        end else begin
            st_d.acc = st_q.acc + CW'(st_q.hits[st_q.idx]);
            if (st_q.idx == st_q.last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + IW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.busy;
    assign idx_o   = st_q.idx;
    assign cnt_o   = st_q.acc;
    assign done_o  = st_q.done;

    p_first_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> (idx_o == '0) && (cnt_o == '0));

    p_cnt_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && idx_o != st_q.last) |=> (cnt_o - $past(cnt_o)) <= CW'(1));

    p_idx_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && idx_o != st_q.last) |=> valid_o && (idx_o == $past(idx_o) + IW'(1)));

    p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && idx_o == st_q.last) |=> done_o && !valid_o);

    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_busy_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && start_i && idx_o != st_q.last) |=> $stable(st_q.last) && $stable(st_q.hits));
endmodule

// File: rtl/prefix_count_top.sv
module prefix_count_top
    import pc_pkg::*;
#(
    parameter int N    = 64,
    parameter int CF_N = 64,
    localparam int IW  = $clog2(N),
    localparam int VLW = $clog2(N + 1),
    localparam int CW  = $clog2(N + 1),
    localparam int CFW = $clog2(CF_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [VLW-1:0]    vl_i,
    input  logic [N-1:0]      src_i,
    input  logic              src_all_i,
    input  logic [N-1:0]      mask_i,
    input  logic              mask_all_i,
    input  logic              cond_mode_i,
    input  logic [4*CF_N-1:0] cond_bank_i,
    input  logic [CFW-1:0]    cond_base_i,
    input  logic [2:0]        cond_sel_i,
    output logic              elem_valid_o,
    output logic [IW-1:0]     elem_idx_o,
    output logic [CW-1:0]     elem_cnt_o,
    output logic              done_o
);
    mode_e        mode;
    logic         vl_ok;
    logic         base_ok;
    logic         start_ok;
    logic [N-1:0] hits;

    always_comb begin
        mode     = cond_mode_i ? MODE_COND : MODE_BITS;
        vl_ok    = (vl_i != '0) && (vl_i <= VLW'(N));
        base_ok  = (mode != MODE_COND) || (cond_base_i != '0);
        start_ok = start_i && vl_ok && base_ok;
    end

    pc_hit_vec #(.N(N), .CF_N(CF_N)) u_hits (
        .mode_i     (mode),
        .src_i      (src_i),
        .src_all_i  (src_all_i),
        .mask_i     (mask_i),
        .mask_all_i (mask_all_i),
        .bank_i     (cond_bank_i),
        .base_i     (cond_base_i),
        .sel_i      (cond_sel_i),
        .hits_o     (hits)
    );

    pc_seq #(.N(N)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start_ok),
        .vl_i    (vl_i),
        .hits_i  (hits),
        .valid_o (elem_valid_o),
        .idx_o   (elem_idx_o),
        .cnt_o   (elem_cnt_o),
        .done_o  (done_o)
    );

    p_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !elem_valid_o && cond_mode_i && cond_base_i == '0) |=> !elem_valid_o);

    p_reject_vl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !elem_valid_o && !vl_ok) |=> !elem_valid_o);
endmodule

// File: tb/prefix_count_top_bench.sv
`timescale 1ns/1ps
module prefix_count_top_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [6:0]   vl_i = '0;
    logic [63:0]  src_i = '0;
    logic         src_all_i = 1'b0;
    logic [63:0]  mask_i = '0;
    logic         mask_all_i = 1'b0;
    logic         cond_mode_i = 1'b0;
    logic [255:0] cond_bank_i = '0;
    logic [5:0]   cond_base_i = '0;
    logic [2:0]   cond_sel_i = '0;
    logic         elem_valid_o;
    logic [5:0]   elem_idx_o;
    logic [6:0]   elem_cnt_o;
    logic         done_o;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    prefix_count_top u_prefix_count_top (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vl_i(vl_i),
        .src_i(src_i), .src_all_i(src_all_i), .mask_i(mask_i),
        .mask_all_i(mask_all_i), .cond_mode_i(cond_mode_i),
        .cond_bank_i(cond_bank_i), .cond_base_i(cond_base_i),
        .cond_sel_i(cond_sel_i), .elem_valid_o(elem_valid_o),
        .elem_idx_o(elem_idx_o), .elem_cnt_o(elem_cnt_o), .done_o(done_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [63:0] ref_hits();
        logic [63:0] h;
        for (int i = 0; i < 64; i++) begin
            logic s;
            logic [3:0] f;
            int fi;
            fi = (int'(cond_base_i) + i) % 64;
            f  = cond_bank_i[fi*4 +: 4];
            if (cond_mode_i) s = (f[cond_sel_i[1:0]] == cond_sel_i[2]);
            else             s = src_all_i | src_i[i];
            h[i] = s & (mask_all_i | mask_i[i]);
        end
        return h;
    endfunction

    // Launch with current inputs, then check the full stream and done timing.
    task automatic run_stream(input string req, input bit busy_poke);
        logic [63:0] h;
        int vl;
        int acc;
        h   = ref_hits();
        vl  = int'(vl_i);
        acc = 0;
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        for (int j = 0; j < vl; j++) begin
            check(elem_valid_o === 1'b1, {req, " valid"}, int'(elem_valid_o), 1);
            check(elem_idx_o == 6'(j), {req, " R7 index"}, int'(elem_idx_o), j);
            check(elem_cnt_o == 7'(acc), {req, " count"}, int'(elem_cnt_o), acc);
            check(done_o === 1'b0, {req, " R8 early done"}, int'(done_o), 0);
            acc += int'(h[j]);
            if (busy_poke && j == 2) begin
                start_i = 1'b1; vl_i = 7'd2; src_i = '0;
            end else begin
                start_i = 1'b0;
            end
            @(negedge clk);
        end
        start_i = 1'b0;
        check(done_o === 1'b1, {req, " R8 done"}, int'(done_o), 1);
        check(elem_valid_o === 1'b0, {req, " R8 valid low"}, int'(elem_valid_o), 0);
        @(negedge clk);
        check(done_o === 1'b0, {req, " R8 single pulse"}, int'(done_o), 0);
    endtask

    task automatic expect_ignored(input string req);
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
        for (int k = 0; k < 4; k++) begin
            check(elem_valid_o === 1'b0 && done_o === 1'b0, req,
                  int'(elem_valid_o) + int'(done_o), 0);
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        check(elem_valid_o === 1'b0, "R10 valid", int'(elem_valid_o), 0);
        check(done_o === 1'b0, "R10 done", int'(done_o), 0);
    endtask

    task automatic t_masked();
        cond_mode_i = 0; src_all_i = 0; mask_all_i = 0;
        src_i = 64'hF0F0_1234_DEAD_BEEF; mask_i = 64'hFFFF_0000_FF0F_F7FF;
        vl_i = 7'd40;
        run_stream("R1 R2 masked", 1'b0);
        src_i = 64'h8000_0000_0000_0001; mask_i = '1; vl_i = 7'd64;
        run_stream("R1 ends", 1'b0);
    endtask

    task automatic t_mask_flag();
        cond_mode_i = 0; src_all_i = 0; mask_all_i = 1;
        src_i = 64'h0123_4567_89AB_CDEF; mask_i = '0; vl_i = 7'd33;
        run_stream("R3 mask all", 1'b0);
    endtask

    task automatic t_src_flag();
        cond_mode_i = 0; src_all_i = 1; mask_all_i = 1;
        src_i = '0; mask_i = '0; vl_i = 7'd64;
        run_stream("R4 iota", 1'b0);
        mask_all_i = 0; mask_i = 64'h5555_5555_5555_5555; vl_i = 7'd1;
        run_stream("R4 R7 vl one", 1'b0);
    endtask

    task automatic t_cond();
        cond_mode_i = 1; src_all_i = 0; src_i = '0; mask_all_i = 1;
        cond_bank_i = {64'hA5C3_1E7F_0B96_D248, 64'h3C69_F00D_7E81_24BD,
                       64'h9F1B_66A2_C0DE_5577, 64'h0FF0_8421_1248_E3B5};
        cond_base_i = 6'd5; cond_sel_i = 3'b110; vl_i = 7'd20;
        run_stream("R5 cond", 1'b0);
        cond_base_i = 6'd60; cond_sel_i = 3'b001; mask_all_i = 0;
        mask_i = 64'hFFFF_FFFF_FFFF_FFEF; vl_i = 7'd12;
        run_stream("R5 R2 cond wrap", 1'b0);
    endtask

    task automatic t_rejects();
        cond_mode_i = 1; cond_base_i = '0; vl_i = 7'd8;
        expect_ignored("R6 base zero");
        cond_mode_i = 0; src_all_i = 1; vl_i = 7'd0;
        expect_ignored("R7 vl zero");
        vl_i = 7'd65;
        expect_ignored("R7 vl too big");
    endtask

    task automatic t_busy();
        cond_mode_i = 0; src_all_i = 0; mask_all_i = 1;
        src_i = 64'h0000_0000_0000_03B7; vl_i = 7'd10;
        run_stream("R9 busy start", 1'b1);
        src_i = 64'h0000_0000_0000_03B7; vl_i = 7'd10;
        expect_idle_after();
    endtask

    task automatic expect_idle_after();
        check(elem_valid_o === 1'b0, "R9 no restart", int'(elem_valid_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked();
        t_mask_flag();
        t_src_flag();
        t_cond();
        t_rejects();
        t_busy();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule